// File: doc/BRIEF.md
# Funnel-Shift Field Extract and Insert Unit

This unit extracts or inserts bit fields in a 32-bit datapath. Two operand words, a left word and a right word, are joined into a 64-bit value. The unit shifts that value left and keeps the upper word. A mask then keeps only the low bits of the shifted word. In insert mode, bits of the right operand are merged back in around the extracted field. The result therefore overlays a shifted field onto the right word.

The shift amount, mask length and insert flag come from a 16-bit field descriptor. Two stored words can supply it: a field register with its own write port, and a latched copy of an immediate bus word. A select input chooses between them on each operation, so the two operation flavours differ only in where the descriptor comes from. The result is registered by default. It appears one cycle after the operation strobe, together with a flag that reports a descriptor field out of range.

Top module: `fu_field_unit`

## Requirements
- R1: After reset the field register and the immediate latch hold zero, and `valid_o`, `result_o` and `desc_err_o` are all zero.
- R2: A shift of 0 selects the left operand unchanged as the shifted word.
- R3: A shift of 32 selects the right operand unchanged as the shifted word.
- R4: For a shift s from 1 to 31, the shifted word is `(left << s) | (right >> (32-s))`, which is the upper half of `{left,right} << s`.
- R5: The shifted word is ANDed with a mask whose low m bits are ones and whose other bits are zeros. A mask length of 32 keeps every bit and a length of 0 keeps none.
- R6: When the insert flag is set, the result is the masked shifted word ORed with `right & ~(ones(m) ^ ones(s))`. Here `ones(n)` is a word whose low n bits are set.
- R7: The descriptor word is the field register when `use_imm_i`=0 and the immediate latch when `use_imm_i`=1. Only its bits [15:0] are used: shift in [5:0], mask length in [11:6], insert flag in [12]. Bits [15:13] and [31:16] have no effect.
- R8: When `fld_we_i`=1 at a clock edge, the field register takes `fld_wdata_i`, and the next operation uses that value. When `fld_we_i`=0, the register keeps its value. The immediate latch works the same way through `imm_we_i` and `imm_i`.
- R9: A shift or mask field above 32 is treated as 32, and `desc_err_o` is raised together with that operation's result.
- R10: With the output register enabled, `valid_o`, `result_o` and `desc_err_o` reflect the operation strobed by `op_valid_i` one cycle earlier. `result_o` holds its value through cycles with no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fld_we_i | input | 1 | Write strobe for the field register |
| fld_wdata_i | input | 32 | Write data for the field register |
| imm_we_i | input | 1 | Latch strobe for the immediate word |
| imm_i | input | 32 | Immediate bus word |
| op_valid_i | input | 1 | Operation strobe |
| use_imm_i | input | 1 | Descriptor source: 0 selects the field register, 1 selects the immediate latch |
| left_i | input | 32 | Left operand, the upper word of the funnel |
| right_i | input | 32 | Right operand, the lower word of the funnel and the insert background |
| result_o | output | 32 | Field result |
| valid_o | output | 1 | Result valid |
| desc_err_o | output | 1 | Descriptor field was out of range |

## Verification
The assertions assume the unit is built with the output register enabled. They also assume a descriptor is stored in the cycle before the operation that uses it, so the stored value is stable when the operation is strobed. The stimulus keeps to this rule: every descriptor write or latch is issued one cycle ahead of its operation and is then dropped. Strobe-free gaps are inserted between operations so the hold behaviour can be observed. Shift and mask values above 32 are driven on purpose, and the bench expects the saturated result and the error flag for them.

// File: rtl/fu_pkg.sv
package fu_pkg;
  typedef enum logic {
    SRC_FIELD = 1'b0,
    SRC_IMM   = 1'b1
  } desc_src_e;
endpackage

// File: rtl/fu_desc_dec.sv
module fu_desc_dec #(
  parameter int W  = 32,
  parameter int SW = $clog2(W) + 1
) (
  input  logic [W-1:0]  word_i,
  output logic [SW-1:0] shift_o,
  output logic [SW-1:0] mask_o,
  output logic          ins_o,
  output logic          err_o
);
  localparam int MK_LSB  = SW;
  localparam int INS_BIT = 2 * SW;
  localparam logic [SW-1:0] LIMIT = SW'(W);

  logic [SW-1:0] raw_sh, raw_mk;
  logic          sh_big, mk_big;

  assign raw_sh = word_i[SW-1:0];
  assign raw_mk = word_i[MK_LSB+SW-1:MK_LSB];
  assign sh_big = raw_sh > LIMIT;
  assign mk_big = raw_mk > LIMIT;

  assign shift_o = sh_big ? LIMIT : raw_sh;
  assign mask_o  = mk_big ? LIMIT : raw_mk;
  assign ins_o   = word_i[INS_BIT];
  assign err_o   = sh_big | mk_big;
endmodule

// File: rtl/fu_funnel.sv
module fu_funnel #(
  parameter int W  = 32,
  parameter int SW = $clog2(W) + 1
) (
  input  logic [W-1:0]  left_i,
  input  logic [W-1:0]  right_i,
  input  logic [SW-1:0] shift_i,
  output logic [W-1:0]  out_o
);
  logic [2*W-1:0] cat;

  // shift <= W, so 0 yields left and W yields right
  assign cat   = {left_i, right_i} << shift_i;
  assign out_o = cat[2*W-1:W];
endmodule

// File: rtl/fu_merge.sv
module fu_merge #(
  parameter int W  = 32,
  parameter int SW = $clog2(W) + 1
) (
  input  logic [W-1:0]  shv_i,
  input  logic [W-1:0]  right_i,
  input  logic [SW-1:0] shift_i,
  input  logic [SW-1:0] mask_i,
  input  logic          ins_i,
  output logic [W-1:0]  res_o
);
  logic [W-1:0] mk_ones, sh_ones, hole;

  for (genvar i = 0; i < W; i++) begin : g_thermo
    assign mk_ones[i] = mask_i  > SW'(i);
    assign sh_ones[i] = shift_i > SW'(i);
  end

  assign hole  = ~(mk_ones ^ sh_ones);
  assign res_o = (shv_i & mk_ones) | (ins_i ? (right_i & hole) : '0);
endmodule

// File: rtl/fu_field_unit.sv
module fu_field_unit #(
  parameter int W       = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fld_we_i,
  input  logic [W-1:0] fld_wdata_i,
  input  logic         imm_we_i,
  input  logic [W-1:0] imm_i,
  input  logic         op_valid_i,
  input  logic         use_imm_i,
  input  logic [W-1:0] left_i,
  input  logic [W-1:0] right_i,
  output logic [W-1:0] result_o,
  output logic         valid_o,
  output logic         desc_err_o
);
  import fu_pkg::*;
  localparam int SW = $clog2(W) + 1;

  logic [W-1:0]  fld_q, imm_q, desc_word, shv, res_c;
  logic [SW-1:0] shift, mask;
  logic          ins, err_c;
  desc_src_e     src;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fld_q <= '0;
      imm_q <= '0;
    end else begin
      if (fld_we_i) fld_q <= fld_wdata_i;
      if (imm_we_i) imm_q <= imm_i;
    end
  end

  assign src       = desc_src_e'(use_imm_i);
  assign desc_word = (src == SRC_IMM) ? imm_q : fld_q;

  fu_desc_dec #(.W(W), .SW(SW)) u_dec (
    .word_i (desc_word),
    .shift_o(shift),
    .mask_o (mask),
    .ins_o  (ins),
    .err_o  (err_c)
  );

  fu_funnel #(.W(W), .SW(SW)) u_funnel (
    .left_i (left_i),
    .right_i(right_i),
    .shift_i(shift),
    .out_o  (shv)
  );

  fu_merge #(.W(W), .SW(SW)) u_merge (
    .shv_i  (shv),
    .right_i(right_i),
    .shift_i(shift),
    .mask_i (mask),
    .ins_i  (ins),
    .res_o  (res_c)
  );

  if (OUT_REG) begin : g_oreg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        result_o   <= '0;
        desc_err_o <= 1'b0;
        valid_o    <= 1'b0;
      end else begin
        valid_o <= op_valid_i;
        if (op_valid_i) begin
          result_o   <= res_c;
          desc_err_o <= err_c;
        end
      end
    end
  end else begin : g_comb
    assign result_o   = res_c;
    assign desc_err_o = err_c & op_valid_i;
    assign valid_o    = op_valid_i;
  end
endmodule

// File: rtl/fu_field_unit_chk.sv
module fu_field_unit_chk #(
  parameter int W       = 32,
  parameter bit OUT_REG = 1'b1
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         fld_we_i,
  input logic [W-1:0] fld_wdata_i,
  input logic         imm_we_i,
  input logic [W-1:0] imm_i,
  input logic         op_valid_i,
  input logic         use_imm_i,
  input logic [W-1:0] left_i,
  input logic [W-1:0] right_i,
  input logic [W-1:0] result_o,
  input logic         valid_o,
  input logic         desc_err_o,
  input logic [W-1:0] fld_q,
  input logic [W-1:0] imm_q
);
  localparam int SW = $clog2(W) + 1;
  localparam logic [SW-1:0] LIMIT = SW'(W);

  logic [W-1:0]  sel;
  logic [SW-1:0] f_sh, f_mk;
  logic          f_ins;

  assign sel   = use_imm_i ? imm_q : fld_q;
  assign f_sh  = sel[SW-1:0];
  assign f_mk  = sel[2*SW-1:SW];
  assign f_ins = sel[2*SW];

  assert_fld_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fld_we_i |=> fld_q == $past(fld_wdata_i));
  assert_fld_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fld_we_i |=> $stable(fld_q));
  assert_imm_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imm_we_i |=> imm_q == $past(imm_i));

  if (OUT_REG) begin : g_seq
    assert_valid_lat_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o == $past(op_valid_i));
    assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !op_valid_i |=> $stable(result_o));
    assert_pass_left_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_valid_i && f_sh == '0 && f_mk == LIMIT && !f_ins) |=> result_o == $past(left_i));
    assert_pass_right_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_valid_i && f_sh == LIMIT && f_mk == LIMIT && !f_ins) |=> result_o == $past(right_i));
    assert_zero_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_valid_i && f_mk == '0 && !f_ins) |=> result_o == '0);
    assert_range_err_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_valid_i && (f_sh > LIMIT || f_mk > LIMIT)) |=> desc_err_o);
  end
endmodule

bind fu_field_unit fu_field_unit_chk #(.W(W), .OUT_REG(OUT_REG)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fld_we_i   (fld_we_i),
  .fld_wdata_i(fld_wdata_i),
  .imm_we_i   (imm_we_i),
  .imm_i      (imm_i),
  .op_valid_i (op_valid_i),
  .use_imm_i  (use_imm_i),
  .left_i     (left_i),
  .right_i    (right_i),
  .result_o   (result_o),
  .valid_o    (valid_o),
  .desc_err_o (desc_err_o),
  .fld_q      (fld_q),
  .imm_q      (imm_q)
);

// File: tb/fu_field_unit_bench.sv
`timescale 1ns/1ps
module fu_field_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fld_we = 1'b0, imm_we = 1'b0, op_valid = 1'b0, use_imm = 1'b0;
  logic [31:0] fld_wdata = '0, imm_w = '0, left = '0, right = '0;
  logic [31:0] result;
  logic        valid, derr;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [32:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] m_fld = '0, m_imm = '0;

  always #5 clk = ~clk;

  fu_field_unit u_fu_field_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .fld_we_i(fld_we), .fld_wdata_i(fld_wdata),
    .imm_we_i(imm_we), .imm_i(imm_w),
    .op_valid_i(op_valid), .use_imm_i(use_imm),
    .left_i(left), .right_i(right),
    .result_o(result), .valid_o(valid), .desc_err_o(derr)
  );

  function automatic logic [31:0] ones(input int n);
    logic [32:0] t;
    t = (33'd1 << n) - 33'd1;
    return t[31:0];
  endfunction

  // reference: {err, result}
  function automatic logic [32:0] ref_model(input logic [31:0] l, r, d);
    int s, m;
    logic [63:0] c;
    logic [31:0] v;
    bit e;
    s = int'(d[5:0]);
    m = int'(d[11:6]);
    e = (s > 32) || (m > 32);
    if (s > 32) s = 32;
    if (m > 32) m = 32;
    c = {l, r};
    c = c << s;
    v = c[63:32] & ones(m);
    if (d[12]) v = v | (r & ~(ones(m) ^ ones(s)));
    return {e, v};
  endfunction

  function automatic logic [31:0] mkd(input int s, m, bit ins);
    return {19'h0, ins, 6'(m), 6'(s)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [32:0] act, exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op_only(input logic [31:0] l, r, input bit imm, input string req);
    op_valid = 1'b1; use_imm = imm; left = l; right = r;
    exp_q.push_back(ref_model(l, r, imm ? m_imm : m_fld));
    tag_q.push_back(req);
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic run_op(input logic [31:0] l, r, d, input bit imm, input string req);
    @(negedge clk);
    if (imm) begin imm_we = 1'b1; imm_w = d; m_imm = d; end
    else     begin fld_we = 1'b1; fld_wdata = d; m_fld = d; end
    @(negedge clk);
    imm_we = 1'b0; fld_we = 1'b0;
    op_only(l, r, imm, req);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk); #1;
      if (rst_n && valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10 unexpected valid", {derr, result}, 33'h0);
        end else begin
          logic [32:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({derr, result} === e, t, {derr, result}, e);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] hold;
    repeat (3) @(negedge clk);
    check(result === '0 && valid === 1'b0 && derr === 1'b0, "R1 reset outputs",
          {derr, result}, 33'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: stored descriptors are zero -> mask 0 -> result 0
    op_only(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R1 field reg zero");
    op_only(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R1 imm latch zero");

    run_op(32'hDEAD_BEEF, 32'h1234_5678, mkd(0, 32, 0), 0, "R2 shift0 left");
    run_op(32'hDEAD_BEEF, 32'h1234_5678, mkd(32, 32, 0), 1, "R3 shift32 right");
    run_op(32'h8000_0001, 32'hF000_000F, mkd(4, 32, 0), 0, "R4 funnel 4");
    run_op(32'hA5A5_A5A5, 32'h5A5A_5A5A, mkd(31, 32, 0), 1, "R4 funnel 31");
    run_op(32'h0123_4567, 32'h89AB_CDEF, mkd(1, 32, 0), 0, "R4 funnel 1");
    run_op(32'hFFFF_FFFF, 32'h0, mkd(0, 0, 0), 0, "R5 mask 0");
    run_op(32'hFFFF_FFFF, 32'h0, mkd(0, 7, 0), 1, "R5 mask 7");
    run_op(32'h0000_00AB, 32'hCCCC_CCCC, mkd(8, 16, 1), 0, "R6 insert 8/16");
    run_op(32'h1111_1111, 32'hEEEE_EEEE, mkd(0, 0, 1), 1, "R6 insert 0/0");
    run_op(32'h1111_1111, 32'hEEEE_EEEE, mkd(32, 32, 1), 0, "R6 insert 32/32");
    run_op(32'h1234_5678, 32'h9ABC_DEF0, mkd(20, 4, 1), 1, "R6 insert shift>mask");
    // R7: upper and spare bits ignored
    run_op(32'hCAFE_F00D, 32'h0BAD_0BAD, 32'hFFFF_E000 | mkd(12, 20, 0), 0, "R7 high bits ignored");
    // R7: source select with differing contents
    @(negedge clk);
    fld_we = 1'b1; fld_wdata = mkd(0, 32, 0); m_fld = fld_wdata;
    imm_we = 1'b1; imm_w = mkd(32, 32, 0); m_imm = imm_w;
    @(negedge clk);
    fld_we = 1'b0; imm_we = 1'b0;
    op_only(32'h1111_2222, 32'h3333_4444, 1'b0, "R7 select field");
    op_only(32'h1111_2222, 32'h3333_4444, 1'b1, "R7 select imm");
    // R8: data change without strobe has no effect
    fld_wdata = mkd(32, 0, 0); imm_w = mkd(0, 0, 0);
    @(negedge clk);
    op_only(32'h5555_AAAA, 32'h0F0F_F0F0, 1'b0, "R8 field kept");
    op_only(32'h5555_AAAA, 32'h0F0F_F0F0, 1'b1, "R8 imm kept");
    // R9: out of range
    run_op(32'h1234_5678, 32'h9ABC_DEF0, mkd(40, 32, 0), 0, "R9 shift>32");
    run_op(32'h1234_5678, 32'h9ABC_DEF0, mkd(5, 63, 1), 1, "R9 mask>32");
    // R10: hold across idle cycles
    repeat (4) @(negedge clk);
    hold = result;
    repeat (3) @(negedge clk);
    check(result === hold && valid === 1'b0, "R10 hold idle", {derr, result}, {1'b0, hold});
    // random sweep R4/R5/R6
    for (int i = 0; i < 60; i++) begin
      int s, m;
      s = (i % 7 == 0) ? 0 : (i % 7 == 1) ? 32 : $urandom_range(0, 32);
      m = (i % 5 == 0) ? 0 : (i % 5 == 1) ? 32 : $urandom_range(0, 32);
      run_op($urandom, $urandom, mkd(s, m, i[0]), i[1], "R6 random");
    end
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R10 all results seen", 33'(exp_q.size()), 33'h0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule